// File: doc/BRIEF.md
# Armed Configuration Byte Readback

This block sits beside the program-memory load path of a small processor core and lets software read the device's fuse and lock configuration bytes. Software arms the block by writing a control register with two command bits set together, the configuration-select bit and the self-program enable bit. For a short, cycle-counted window after that write, a program-memory load instruction no longer returns flash data. Instead it returns one of four configuration bytes, chosen by the two lowest bits of the load address.

The command bits clear by themselves. They clear when the armed load has been served, when a store instruction consumes them, or when the window lapses without a load. While the nonvolatile data memory reports a write in progress, the block refuses to arm and drops any armed state, so loads return ordinary flash data. The configuration bytes arrive on input ports in their stored polarity: a programmed bit is 0 and an unprogrammed bit is 1. The flash array and the CPU pipeline are outside this block. The flash read data for each load is presented on an input port.

Top module: `cfgrb_top`

## Requirements
- R1: A control write with bit 3 (configuration select) and bit 0 (self-program enable) both set, while `ee_busy` is low, makes `ctrl_rdata` read 8'h09 from the next cycle. Every other control bit always reads 0.
- R2: A control write that does not set both bit 3 and bit 0 leaves both command bits clear, and it also clears them if they were armed.
- R3: A load issued in any of the first three cycles after the arming write returns a configuration byte chosen by address bits [1:0]: 0 gives fuse low, 1 gives the lock byte, 2 gives extended fuse, 3 gives fuse high. Address bits above bit 1 have no effect on the choice.
- R4: The cycle after an armed load is accepted, `ctrl_rdata` reads 0.
- R5: With no load and no store, the command bits clear after the third cycle following the arming write. The window is the shorter of the load window (3) and the store window (4). A load in the fourth cycle returns flash data.
- R6: A store strobe while armed clears the command bits on the next cycle. A later load returns flash data.
- R7: The lock byte returns the two lock inputs in bits [1:0] and 1 in bits [7:2]. Fuse bytes are returned unchanged, so programmed bits read 0 and unprogrammed bits read 1.
- R8: While `ee_busy` is high, control writes are ignored and the command bits are forced clear on the next edge. A load in such a cycle returns flash data even if the block was armed.
- R9: Every load raises `rd_valid` for exactly one cycle, one cycle after the strobe, with `rd_data` registered at that edge. A load made while not armed returns `flash_rdata`.
- R10: After reset, `ctrl_rdata`, `rd_data` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| ld_req | input | 1 | Program-memory load strobe |
| ld_addr | input | ADDR_W | Load address pointer |
| st_req | input | 1 | Program-memory store strobe |
| ee_busy | input | 1 | Nonvolatile data memory write in progress |
| flash_rdata | input | 8 | Ordinary program-memory read byte for the current load |
| fuse_lo | input | 8 | Fuse low byte |
| fuse_hi | input | 8 | Fuse high byte |
| fuse_ext | input | 8 | Extended fuse byte |
| lock_bits | input | LOCK_W | Lock bits |
| rd_data | output | 8 | Registered load result |
| rd_valid | output | 1 | Load result valid, one cycle after the strobe |
| ctrl_rdata | output | 8 | Control register readback |

## Verification
The bench uses the default parameters: a 16-bit address, two lock bits, a load window of 3 and a store window of 4. With these defaults the effective window is three cycles, and the bench can place loads exactly at the last accepted cycle and at the first rejected one. The 16-bit address lets the bench set high address bits and show that only bits [1:0] select the byte. Two lock bits leave six padding bits in the lock byte, and the bench checks that they read as 1.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;

  localparam int BYTE_W = 8;

  // Selection order is fixed by address bits [1:0].
  typedef enum logic [1:0] {
    SEL_FUSE_LO  = 2'd0,
    SEL_LOCK     = 2'd1,
    SEL_FUSE_EXT = 2'd2,
    SEL_FUSE_HI  = 2'd3
  } cfg_sel_e;

  function automatic cfg_sel_e addr_to_sel(input logic [1:0] lo);
    return cfg_sel_e'(lo);
  endfunction

endpackage

// File: rtl/cfgrb_window.sv
module cfgrb_window #(
  parameter int BYTE_W  = 8,
  parameter int CFG_BIT = 3,
  parameter int EN_BIT  = 0,
  parameter int LIMIT   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ld_req,
  input  logic              st_req,
  input  logic              ee_busy,
  output logic              armed,
  output logic [BYTE_W-1:0] ctrl_q
);

  localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
  localparam logic [BYTE_W-1:0] CMD_MASK =
    (BYTE_W'(1) << CFG_BIT) | (BYTE_W'(1) << EN_BIT);

  logic             armed_q;
  logic [CNT_W-1:0] age_q;
  logic             arm_cmd;

  assign arm_cmd = wr_data[CFG_BIT] & wr_data[EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      age_q   <= '0;
    end else if (ee_busy) begin
      armed_q <= 1'b0;
      age_q   <= '0;
    end else if (wr_en) begin
      armed_q <= arm_cmd;
      age_q   <= '0;
    end else if (armed_q) begin
      if (ld_req || st_req || age_q == LAST) begin
        armed_q <= 1'b0;
        age_q   <= '0;
      end else begin
        age_q <= age_q + 1'b1;
      end
    end
  end

  assign armed  = armed_q;
  assign ctrl_q = armed_q ? CMD_MASK : '0;

endmodule

// File: rtl/cfgrb_mux.sv
module cfgrb_mux
  import cfgrb_pkg::*;
#(
  parameter int LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_req,
  input  logic [1:0]        sel_bits,
  input  logic              use_cfg,
  input  logic [BYTE_W-1:0] flash_rdata,
  input  logic [BYTE_W-1:0] fuse_lo,
  input  logic [BYTE_W-1:0] fuse_hi,
  input  logic [BYTE_W-1:0] fuse_ext,
  input  logic [LOCK_W-1:0] lock_bits,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [BYTE_W-1:0] lock_byte;
  logic [BYTE_W-1:0] cfg_byte;

  genvar gi;
  generate
    for (gi = 0; gi < BYTE_W; gi++) begin : g_lock
      if (gi < LOCK_W) begin : g_bit
        assign lock_byte[gi] = lock_bits[gi];
      end else begin : g_pad
        assign lock_byte[gi] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    unique case (addr_to_sel(sel_bits))
      SEL_FUSE_LO:  cfg_byte = fuse_lo;
      SEL_LOCK:     cfg_byte = lock_byte;
      SEL_FUSE_EXT: cfg_byte = fuse_ext;
      SEL_FUSE_HI:  cfg_byte = fuse_hi;
      default:      cfg_byte = fuse_lo;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= ld_req;
      if (ld_req) rd_data <= use_cfg ? cfg_byte : flash_rdata;
    end
  end

endmodule

// File: rtl/cfgrb_top.sv
module cfgrb_top
  import cfgrb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LOCK_W  = 2,
  parameter int LD_WIN  = 3,
  parameter int ST_WIN  = 4,
  parameter int CFG_BIT = 3,
  parameter int EN_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_req,
  input  logic              ee_busy,
  input  logic [7:0]        flash_rdata,
  input  logic [7:0]        fuse_lo,
  input  logic [7:0]        fuse_hi,
  input  logic [7:0]        fuse_ext,
  input  logic [LOCK_W-1:0] lock_bits,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic [7:0]        ctrl_rdata
);

  localparam int LIMIT = (LD_WIN < ST_WIN) ? LD_WIN : ST_WIN;

  logic armed;
  logic use_cfg;
  logic unused_addr_hi;

  assign unused_addr_hi = ^ld_addr[ADDR_W-1:2];
  assign use_cfg = armed & ~ee_busy;

  cfgrb_window #(
    .BYTE_W (BYTE_W),
    .CFG_BIT(CFG_BIT),
    .EN_BIT (EN_BIT),
    .LIMIT  (LIMIT)
  ) u_win (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr),
    .wr_data(reg_wdata),
    .ld_req (ld_req),
    .st_req (st_req),
    .ee_busy(ee_busy),
    .armed  (armed),
    .ctrl_q (ctrl_rdata)
  );

  cfgrb_mux #(
    .LOCK_W(LOCK_W)
  ) u_mux (
    .clk        (clk),
    .rst        (rst),
    .ld_req     (ld_req),
    .sel_bits   (ld_addr[1:0]),
    .use_cfg    (use_cfg),
    .flash_rdata(flash_rdata),
    .fuse_lo    (fuse_lo),
    .fuse_hi    (fuse_hi),
    .fuse_ext   (fuse_ext),
    .lock_bits  (lock_bits),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

endmodule

// File: rtl/cfgrb_checker.sv
module cfgrb_checker #(
  parameter int ADDR_W  = 16,
  parameter int LOCK_W  = 2,
  parameter int LIMIT   = 3,
  parameter int CFG_BIT = 3,
  parameter int EN_BIT  = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic              ld_req,
  input logic [ADDR_W-1:0] ld_addr,
  input logic              st_req,
  input logic              ee_busy,
  input logic [7:0]        rd_data,
  input logic              rd_valid,
  input logic [7:0]        ctrl_rdata
);

  localparam int AGE_W = $clog2(LIMIT + 2);

  logic [AGE_W-1:0] age_q;
  logic             armed_now;

  assign armed_now = ctrl_rdata[CFG_BIT];

  always_ff @(posedge clk) begin
    if (rst || reg_wr || !armed_now) age_q <= '0;
    else if (age_q != '1) age_q <= age_q + 1'b1;
  end

  // R1: command bits only rise after an accepted arming write
  a_r1_rise_needs_write: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_rdata[EN_BIT]) |-> $past(reg_wr && reg_wdata[CFG_BIT] && reg_wdata[EN_BIT] && !ee_busy));

  // R4: served armed load clears the bits
  a_r4_clear_after_load: assert property (@(posedge clk) disable iff (rst)
    (armed_now && ld_req && !reg_wr) |=> (ctrl_rdata == 8'h00));

  // R5: armed state never outlives the window
  a_r5_window_bound: assert property (@(posedge clk) disable iff (rst)
    armed_now |-> (age_q < AGE_W'(LIMIT)));

  // R6: store consumes the armed bits
  a_r6_store_clears: assert property (@(posedge clk) disable iff (rst)
    (armed_now && st_req && !reg_wr) |=> (ctrl_rdata == 8'h00));

  // R7: padding bits of the lock byte read as one
  a_r7_lock_pad: assert property (@(posedge clk) disable iff (rst)
    (armed_now && ld_req && !ee_busy && ld_addr[1:0] == 2'd1)
      |=> (rd_data[7:LOCK_W] == '1));

  // R8: busy forces the bits clear
  a_r8_busy_clears: assert property (@(posedge clk) disable iff (rst)
    ee_busy |=> (ctrl_rdata == 8'h00));

  // R9: valid pulse follows each load strobe
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    ld_req |=> rd_valid);
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !ld_req |=> !rd_valid);

endmodule

bind cfgrb_top cfgrb_checker #(
  .ADDR_W (ADDR_W),
  .LOCK_W (LOCK_W),
  .LIMIT  ((LD_WIN < ST_WIN) ? LD_WIN : ST_WIN),
  .CFG_BIT(CFG_BIT),
  .EN_BIT (EN_BIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .ld_req    (ld_req),
  .ld_addr   (ld_addr),
  .st_req    (st_req),
  .ee_busy   (ee_busy),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .ctrl_rdata(ctrl_rdata)
);

// File: tb/sim_cfgrb_top.sv
`timescale 1ns/1ps
module sim_cfgrb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic        ld_req = 1'b0;
  logic [15:0] ld_addr = 16'h0000;
  logic        st_req = 1'b0;
  logic        ee_busy = 1'b0;
  logic [7:0]  flash_rdata = 8'h5A;
  logic [7:0]  fuse_lo = 8'h62;
  logic [7:0]  fuse_hi = 8'hDF;
  logic [7:0]  fuse_ext = 8'hF9;
  logic [1:0]  lock_bits = 2'b10;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [7:0]  ctrl_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfgrb_top u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ld_req(ld_req), .ld_addr(ld_addr), .st_req(st_req), .ee_busy(ee_busy),
    .flash_rdata(flash_rdata), .fuse_lo(fuse_lo), .fuse_hi(fuse_hi),
    .fuse_ext(fuse_ext), .lock_bits(lock_bits), .rd_data(rd_data),
    .rd_valid(rd_valid), .ctrl_rdata(ctrl_rdata)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic load(input logic [15:0] a);
    ld_req = 1'b1; ld_addr = a;
    @(negedge clk);
    ld_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 ctrl", {8'h0, ctrl_rdata}, 16'h0000);
    chk("R10 rd_data", {8'h0, rd_data}, 16'h0000);
    chk("R10 rd_valid", {15'h0, rd_valid}, 16'h0000);
  endtask

  task automatic t_arm;
    wr_ctrl(8'h09);
    chk("R1 armed readback", {8'h0, ctrl_rdata}, 16'h0009);
    wr_ctrl(8'hFF);
    chk("R1 other bits zero", {8'h0, ctrl_rdata}, 16'h0009);
    idle(4);
  endtask

  task automatic t_partial;
    wr_ctrl(8'h01);
    chk("R2 enable only", {8'h0, ctrl_rdata}, 16'h0000);
    wr_ctrl(8'h08);
    chk("R2 select only", {8'h0, ctrl_rdata}, 16'h0000);
    wr_ctrl(8'h09);
    wr_ctrl(8'h01);
    chk("R2 partial disarms", {8'h0, ctrl_rdata}, 16'h0000);
    load(16'h0000);
    chk("R2 load after disarm", {8'h0, rd_data}, {8'h0, flash_rdata});
  endtask

  task automatic t_readback(input logic [15:0] a, input logic [7:0] exp, input string req);
    wr_ctrl(8'h09);
    load(a);
    chk(req, {8'h0, rd_data}, {8'h0, exp});
    chk("R9 valid", {15'h0, rd_valid}, 16'h0001);
    chk("R4 cleared after load", {8'h0, ctrl_rdata}, 16'h0000);
    idle(1);
    chk("R9 valid one cycle", {15'h0, rd_valid}, 16'h0000);
  endtask

  task automatic t_window;
    wr_ctrl(8'h09);
    idle(2);
    chk("R5 still armed cycle 3", {8'h0, ctrl_rdata}, 16'h0009);
    load(16'h0003);
    chk("R3 load at cycle 3", {8'h0, rd_data}, 16'h00DF);
    wr_ctrl(8'h09);
    idle(3);
    chk("R5 expired", {8'h0, ctrl_rdata}, 16'h0000);
    flash_rdata = 8'hA7;
    load(16'h0001);
    chk("R5 late load flash", {8'h0, rd_data}, 16'h00A7);
  endtask

  task automatic t_store;
    wr_ctrl(8'h09);
    st_req = 1'b1;
    @(negedge clk);
    st_req = 1'b0;
    chk("R6 store clears", {8'h0, ctrl_rdata}, 16'h0000);
    chk("R6 no valid", {15'h0, rd_valid}, 16'h0000);
    flash_rdata = 8'h3C;
    load(16'h0000);
    chk("R6 load after store", {8'h0, rd_data}, 16'h003C);
  endtask

  task automatic t_busy;
    ee_busy = 1'b1;
    wr_ctrl(8'h09);
    chk("R8 write ignored", {8'h0, ctrl_rdata}, 16'h0000);
    ee_busy = 1'b0;
    wr_ctrl(8'h09);
    ee_busy = 1'b1; flash_rdata = 8'h81;
    load(16'h0000);
    chk("R8 load during busy", {8'h0, rd_data}, 16'h0081);
    chk("R8 bits cleared", {8'h0, ctrl_rdata}, 16'h0000);
    ee_busy = 1'b0;
  endtask

  task automatic t_normal;
    flash_rdata = 8'hC4;
    load(16'h0002);
    chk("R9 plain load", {8'h0, rd_data}, 16'h00C4);
    chk("R9 plain valid", {15'h0, rd_valid}, 16'h0001);
  endtask

  initial begin
    idle(2);
    t_reset();
    rst = 1'b0;
    idle(1);
    t_normal();
    t_arm();
    t_partial();
    t_readback(16'h0000, 8'h62, "R3 fuse low");
    t_readback(16'h0001, 8'hFE, "R7 lock byte");
    t_readback(16'h0002, 8'hF9, "R3 fuse ext");
    t_readback(16'h0003, 8'hDF, "R3 fuse high");
    t_readback(16'hABC2, 8'hF9, "R3 high addr bits ignored");
    lock_bits = 2'b01;
    t_readback(16'hFFF1, 8'hFD, "R7 lock bits pass");
    t_window();
    t_store();
    t_busy();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule